// File: doc/BRIEF.md
# PTP Event Timestamp Capture Pair

This block holds one timestamp for the receive path and one for the transmit path of a precision time protocol datapath. A single-cycle event strobe per path stands in for the frame classifier. When a path is enabled and its slot is empty, a strobe copies the current 64-bit time counter value into the slot and sets a valid flag. Once the flag is set, the slot keeps this first value. Later strobes do not overwrite it. They only raise a saturating drop counter.

Software polls the status word. If the valid flag is set, software reads the low and high halves of the timestamp. It then writes the flag bit back as 1, which empties the slot for the next event. Software also writes the valid bit whenever it enables or reconfigures a path, so that no stale value survives. Both paths are reached through one small word-addressed register port, and read data is registered.

Top module: `ts_capture_pair`

## Requirements
- R1: After reset, every register of both paths reads as zero: the valid flag, the drop count, both timestamp halves and the enable field.
- R2: An enabled path with an empty slot captures, at the clock edge where its strobe is high, the `time_now` value present at that edge, and sets status bit 16. The low half reads at word 1 and the high half at word 2 of the path, with timestamp = {high, low}. Read data appears on `bus_rdata` one clock after the edge that samples `bus_rd`.
- R3: While the valid flag is set and no re-arm write arrives, further strobes leave the captured timestamp unchanged.
- R4: Each strobe dropped while the flag is set increments the drop count in status bits 7:0. The count saturates at 255.
- R5: The enable field is bits 2:0 of word 3 and reads back as written. With the value 0, strobes are neither captured nor counted. Any nonzero value enables the path.
- R6: A write to the status word (word 0) with bit 16 set clears the valid flag and the drop count. A status write with bit 16 clear changes nothing.
- R7: If a re-arm write and a strobe arrive in the same cycle on an enabled path, the clear applies first. The strobe is then captured: the flag stays set, the timestamp takes the new time and the count is 0.
- R8: Address bit 3 selects the path (0 = receive at words 0–3, 1 = transmit at words 8–11). The two paths capture, count, enable and re-arm independently. Words with address bit 2 set read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_now | input | 64 | Current value of the time counter |
| rx_event | input | 1 | Receive-path event strobe |
| tx_event | input | 1 | Transmit-path event strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
Every enable code from 0 to 7 is swept: a strobe is issued for each code and the status and timestamp are read back, which separates the disabled code from the seven enabling ones. A burst of 300 strobes after a capture tells a correct hold-and-count apart from an overwrite, and checks the counter both before and after saturation. Timestamp values that differ in both halves are used, which exposes swapped or truncated halves. A re-arm that coincides with a strobe, together with cross-path traffic, separates clear-then-capture ordering and path isolation from their faulty variants.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
  // word select inside one path's four-word window
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_TS_LO  = 2'd1,
    SEL_TS_HI  = 2'd2,
    SEL_ENABLE = 2'd3
  } reg_sel_e;

  localparam int VALID_BIT = 16;
  localparam int NPATH     = 2;
endpackage

// File: rtl/ts_cap_unit.sv
module ts_cap_unit #(
  parameter int TS_W  = 64,
  parameter int CNT_W = 8,
  parameter int EN_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TS_W-1:0]  time_now,
  input  logic             event_i,
  input  logic             rearm_i,
  input  logic             en_wr_i,
  input  logic [EN_W-1:0]  en_wdata_i,
  output logic [EN_W-1:0]  en_q,
  output logic             valid_q,
  output logic [TS_W-1:0]  ts_q,
  output logic [CNT_W-1:0] ovf_q
);
  localparam logic [CNT_W-1:0] OVF_MAX = '1;

  logic enabled, held, take, drop;

  always_comb begin
    enabled = |en_q;
    held    = valid_q & ~rearm_i;   // clear is applied before the event
    take    = event_i & enabled & ~held;
    drop    = event_i & enabled & held;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (en_wr_i) begin
      en_q <= en_wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      ts_q    <= '0;
    end else if (take) begin
      valid_q <= 1'b1;
      ts_q    <= time_now;
    end else if (rearm_i) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q <= '0;
    end else if (rearm_i) begin
      ovf_q <= '0;
    end else if (drop && ovf_q != OVF_MAX) begin
      ovf_q <= ovf_q + 1'b1;
    end
  end

  AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!valid_q && event_i && en_q != '0) |=> (valid_q && ts_q == $past(time_now))) else $error("capture"); // R2
  AST_HOLD_TS: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !rearm_i) |=> $stable(ts_q)) else $error("hold"); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !rearm_i && event_i && en_q != '0 && ovf_q != OVF_MAX)
      |=> (ovf_q == CNT_W'($past(ovf_q) + 1'b1))) else $error("count"); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (ovf_q == OVF_MAX && !rearm_i) |=> (ovf_q == OVF_MAX)) else $error("saturate"); // R4
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
    (en_q == '0 && !valid_q) |=> !valid_q) else $error("disabled"); // R5
  AST_REARM_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (rearm_i && !(event_i && en_q != '0)) |=> (!valid_q && ovf_q == '0)) else $error("rearm"); // R6
  AST_CLEAR_THEN_TAKE: assert property (@(posedge clk) disable iff (rst)
    (rearm_i && event_i && en_q != '0) |=> (valid_q && ovf_q == '0 && ts_q == $past(time_now))) else $error("order"); // R7
endmodule

// File: rtl/ts_cap_regif.sv
module ts_cap_regif
  import ts_cap_pkg::*;
#(
  parameter int TS_W   = 64,
  parameter int CNT_W  = 8,
  parameter int EN_W   = 3,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  input  logic [NPATH-1:0]             valid,
  input  logic [NPATH-1:0][TS_W-1:0]   ts,
  input  logic [NPATH-1:0][CNT_W-1:0]  ovf,
  input  logic [NPATH-1:0][EN_W-1:0]   en,
  output logic [NPATH-1:0]             rearm,
  output logic [NPATH-1:0]             en_wr,
  output logic [EN_W-1:0]              en_wdata,
  output logic [DATA_W-1:0]            bus_rdata
);
  localparam int PAD_HI = ADDR_W - 2;

  logic             addr_ok;
  logic             path;
  reg_sel_e         sel;
  logic [DATA_W-1:0] rd_word;

  always_comb begin
    addr_ok  = (bus_addr[PAD_HI:2] == '0);
    path     = bus_addr[ADDR_W-1];
    sel      = reg_sel_e'(bus_addr[1:0]);
    en_wdata = bus_wdata[EN_W-1:0];
  end

  for (genvar p = 0; p < NPATH; p++) begin : g_dec
    always_comb begin
      rearm[p] = bus_wr && addr_ok && (path == 1'(p)) && sel == SEL_STATUS
                 && bus_wdata[VALID_BIT];
      en_wr[p] = bus_wr && addr_ok && (path == 1'(p)) && sel == SEL_ENABLE;
    end
  end

  always_comb begin
    rd_word = '0;
    if (addr_ok) begin
      case (sel)
        SEL_STATUS: begin
          rd_word[VALID_BIT]  = valid[path];
          rd_word[CNT_W-1:0]  = ovf[path];
        end
        SEL_TS_LO:  rd_word = ts[path][DATA_W-1:0];
        SEL_TS_HI:  rd_word = ts[path][TS_W-1:DATA_W];
        default:    rd_word[EN_W-1:0] = en[path];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_word;
    end
  end

  AST_ONE_PATH_REARM: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rearm | en_wr)) else $error("decode"); // R8
endmodule

// File: rtl/ts_capture_pair.sv
module ts_capture_pair
  import ts_cap_pkg::*;
#(
  parameter int TS_W   = 64,
  parameter int CNT_W  = 8,
  parameter int EN_W   = 3,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TS_W-1:0]   time_now,
  input  logic              rx_event,
  input  logic              tx_event,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  logic [NPATH-1:0]            evt;
  logic [NPATH-1:0]            valid, rearm, en_wr;
  logic [NPATH-1:0][TS_W-1:0]  ts;
  logic [NPATH-1:0][CNT_W-1:0] ovf;
  logic [NPATH-1:0][EN_W-1:0]  en;
  logic [EN_W-1:0]             en_wdata;

  assign evt = {tx_event, rx_event};

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    ts_cap_unit #(.TS_W(TS_W), .CNT_W(CNT_W), .EN_W(EN_W)) u_unit (
      .clk        (clk),
      .rst        (rst),
      .time_now   (time_now),
      .event_i    (evt[p]),
      .rearm_i    (rearm[p]),
      .en_wr_i    (en_wr[p]),
      .en_wdata_i (en_wdata),
      .en_q       (en[p]),
      .valid_q    (valid[p]),
      .ts_q       (ts[p]),
      .ovf_q      (ovf[p])
    );
  end

  ts_cap_regif #(
    .TS_W(TS_W), .CNT_W(CNT_W), .EN_W(EN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regif (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .valid     (valid),
    .ts        (ts),
    .ovf       (ovf),
    .en        (en),
    .rearm     (rearm),
    .en_wr     (en_wr),
    .en_wdata  (en_wdata),
    .bus_rdata (bus_rdata)
  );
endmodule

// File: tb/ts_capture_pair_test.sv
module ts_capture_pair_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] time_now = '0;
  logic        rx_event = 1'b0, tx_event = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int errors = 0;
  int checks = 0;

  localparam logic [31:0] VBIT = 32'h0001_0000;

  ts_capture_pair uut (
    .clk(clk), .rst(rst), .time_now(time_now), .rx_event(rx_event),
    .tx_event(tx_event), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, bus_rdata, exp);
  endtask

  task automatic pulse(input bit tx, input logic [63:0] t);
    @(negedge clk);
    time_now = t;
    if (tx) tx_event = 1'b1; else rx_event = 1'b1;
    @(negedge clk);
    rx_event = 1'b0; tx_event = 1'b0;
  endtask

  task automatic check_ts(input string req, input logic [3:0] base, input logic [63:0] t);
    rd_check(req, base + 4'd1, t[31:0]);
    rd_check(req, base + 4'd2, t[63:32]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] t1, t3, t4;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state across every word of both paths
    for (int a = 0; a < 16; a++) rd_check("R1 reset", 4'(a), 32'h0);

    // R5/R2/R6: sweep all enable codes on the receive path
    for (int v = 0; v < 8; v++) begin
      logic [63:0] t;
      t = {32'hA5A5_0000 + 32'(v), 32'h1234_5600 + 32'(v * 17)};
      wr(4'd3, 32'(v));
      rd_check("R5 enable readback", 4'd3, 32'(v));
      pulse(1'b0, t);
      if (v == 0) begin
        rd_check("R5 disabled ignores", 4'd0, 32'h0);
      end else begin
        rd_check("R2 valid set", 4'd0, VBIT);
        check_ts("R2 timestamp", 4'd0, t);
        wr(4'd0, VBIT);
        rd_check("R6 rearm clears", 4'd0, 32'h0);
      end
    end

    // R3/R4: capture then burst of 300 strobes
    wr(4'd3, 32'd1);
    t1 = 64'h0000_0001_FFFF_FFF0;
    pulse(1'b0, t1);
    pulse(1'b0, 64'h1111_2222_3333_4444);
    rd_check("R4 one drop", 4'd0, VBIT | 32'd1);
    @(negedge clk);
    rx_event = 1'b1;
    for (int i = 0; i < 299; i++) begin
      time_now = 64'h7700_0000_0000_0000 + 64'(i);
      @(negedge clk);
    end
    rx_event = 1'b0;
    rd_check("R4 saturated", 4'd0, VBIT | 32'd255);
    check_ts("R3 first kept", 4'd0, t1);

    // R6: write without bit 16 does nothing
    wr(4'd0, 32'h0000_FFFF);
    rd_check("R6 no-op write", 4'd0, VBIT | 32'd255);
    wr(4'd0, VBIT);
    rd_check("R6 clear count", 4'd0, 32'h0);

    // R7: simultaneous re-arm and strobe
    pulse(1'b0, 64'h0F0F_0F0F_F0F0_F0F0);
    pulse(1'b0, 64'h1);
    pulse(1'b0, 64'h2);
    rd_check("R7 setup", 4'd0, VBIT | 32'd2);
    t3 = 64'hCAFE_0001_BEEF_0002;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'd0; bus_wdata = VBIT;
    rx_event = 1'b1; time_now = t3;
    @(negedge clk);
    bus_wr = 1'b0; rx_event = 1'b0;
    rd_check("R7 recaptured", 4'd0, VBIT);
    check_ts("R7 new time", 4'd0, t3);

    // R8: independent transmit path
    rd_check("R8 tx idle", 4'd8, 32'h0);
    wr(4'd11, 32'd5);
    rd_check("R8 tx enable", 4'd11, 32'd5);
    rd_check("R8 rx enable kept", 4'd3, 32'd1);
    t4 = 64'h0123_4567_89AB_CDEF;
    @(negedge clk);
    time_now = t4; rx_event = 1'b1; tx_event = 1'b1;
    @(negedge clk);
    rx_event = 1'b0; tx_event = 1'b0;
    rd_check("R8 tx valid", 4'd8, VBIT);
    check_ts("R8 tx time", 4'd8, t4);
    rd_check("R8 rx dropped", 4'd0, VBIT | 32'd1);
    check_ts("R8 rx time", 4'd0, t3);
    wr(4'd8, VBIT);
    rd_check("R8 tx rearmed", 4'd8, 32'h0);
    rd_check("R8 rx untouched", 4'd0, VBIT | 32'd1);
    wr(4'd4, VBIT);
    rd_check("R8 hole write ignored", 4'd0, VBIT | 32'd1);
    rd_check("R8 hole reads zero", 4'd5, 32'h0);

    // R5: disabled path does not count
    wr(4'd3, 32'd0);
    pulse(1'b0, 64'h55);
    rd_check("R5 disabled no count", 4'd0, VBIT | 32'd1);
    check_ts("R5 disabled ts", 4'd0, t3);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule